// File: doc/BRIEF.md
# Ternary Bitstream Adder with Carry Feedback

This block adds two ternary bitstreams, one sample per enabled clock, and produces a ternary sum stream. Each sample is one of -1, 0 or +1. When two inputs of the same sign would push the sum outside that range, the excess carry is not dropped. It is held in a three-valued carry register and added into a following output sample. The arithmetic error is therefore mostly a first difference of the carry sequence, which moves its energy toward high frequency. It survives only as a rare clipped carry.

Three ternary half-adders form the datapath. The first adds the two operands into a partial sum and a first carry. The second adds the partial sum to the stored carry, which gives the output sample and a second carry. The third merges the two carries into the next stored carry. A subtract control negates the second operand before the addition. The carry register is written as a three-state machine with the states CARRY_ZERO, CARRY_POS and CARRY_NEG. Each enabled clock moves it to the state named by the merged carry, which can mean staying in the same state. Reset sends it to CARRY_ZERO. While enable is low it holds its state.

Top module: `tern_cf_adder`

## Requirements
- R1: During and after synchronous reset (`rst` high at a rising edge), `sum_code` is 2'b00 and the carry register is in CARRY_ZERO.
- R2: With the carry register in CARRY_ZERO and operands whose sum lies in {-1,0,+1}, the next `sum_code` equals that sum and the carry register stays in CARRY_ZERO.
- R3: With the carry register in CARRY_ZERO and both operands equal and nonzero, the output equals that operand and the carry register moves to the state of that sign (CARRY_POS or CARRY_NEG).
- R4: A stored carry is added into the next sample. For example, CARRY_POS with operands 0 and 0 gives output +1 and a return to CARRY_ZERO.
- R5: A carry is lost only when both operands and the stored carry all have the same nonzero value. The output is then that value and the carry register keeps that value.
- R6: A stored carry of the opposite sign to two equal operands cancels. For example, CARRY_POS with operands -1,-1 gives output 0 and moves the register to CARRY_NEG.
- R7: With `sub_mode` high, the second operand is negated before the addition (+1 and -1 swap, 0 stays 0).
- R8: While `en` is low, `sum_code` and the carry register hold their values whatever the operands are.
- R9: Operand codes are 2'b00 = 0, 2'b01 = +1, 2'b11 = -1. The unused code 2'b10 is read as 0.
- R10: `sum_code` only ever carries 2'b00, 2'b01 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; when high, one sample is added per clock |
| a_code | input | 2 | First ternary operand |
| b_code | input | 2 | Second ternary operand, negated in subtract mode |
| sub_mode | input | 1 | High: subtract `b_code` from `a_code` |
| sum_code | output | 2 | Registered ternary sum |

## Verification
The embedded properties watch every cycle for the following: an output code outside the three legal values, any change in output or carry while enable is low, a clipped carry outside the triple-equal case, and a break in value conservation (operands plus old carry equal output plus new carry) whenever nothing is clipped. These do not show that the stored carry lands in the correct later sample, that subtraction negates the right operand, or that the spare code decodes as zero. Directed scenarios cover those by driving carry chains, the cancelling case, subtract mode and reset, and they compare the output with an arithmetic model of the sum and carry equations.

// File: rtl/tern_pkg.sv
package tern_pkg;

    typedef enum logic [1:0] {
        TZ = 2'b00,
        TP = 2'b01,
        TN = 2'b11
    } trit_e;

    localparam int CODE_W = 2;

    function automatic trit_e trit_decode(input logic [CODE_W-1:0] code);
        trit_e t;
        case (code)
            2'b01:   t = TP;
            2'b11:   t = TN;
            default: t = TZ;
        endcase
        return t;
    endfunction

    function automatic trit_e trit_negate(input trit_e t);
        trit_e r;
        unique case (t)
            TP: r = TN;
            TN: r = TP;
            TZ: r = TZ;
        endcase
        return r;
    endfunction

    function automatic int trit_value(input trit_e t);
        int v;
        unique case (t)
            TP: v = 1;
            TN: v = -1;
            TZ: v = 0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tern_operand_in.sv
module tern_operand_in
    import tern_pkg::*;
#(
    parameter bit CAN_NEGATE = 1'b0
) (
    input  logic [CODE_W-1:0] code,
    input  logic              negate,
    output trit_e             trit
);
    trit_e decoded;
    assign decoded = trit_decode(code);

    generate
        if (CAN_NEGATE) begin : g_neg
            assign trit = negate ? trit_negate(decoded) : decoded;
        end else begin : g_pass
            logic unused_neg;
            assign unused_neg = negate;
            assign trit = decoded;
        end
    endgenerate
endmodule

// File: rtl/tern_half_add.sv
module tern_half_add
    import tern_pkg::*;
(
    input  trit_e lhs,
    input  trit_e rhs,
    output trit_e sum,
    output trit_e carry
);
    always_comb begin
        sum   = TZ;
        carry = TZ;
        unique case (lhs)
            TZ: sum = rhs;
            TP: begin
                unique case (rhs)
                    TZ: sum = TP;
                    TN: sum = TZ;
                    TP: begin
                        sum   = TP;
                        carry = TP;
                    end
                endcase
            end
            TN: begin
                unique case (rhs)
                    TZ: sum = TN;
                    TP: sum = TZ;
                    TN: begin
                        sum   = TN;
                        carry = TN;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/tern_cf_adder.sv
module tern_cf_adder
    import tern_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] a_code,
    input  logic [1:0] b_code,
    input  logic       sub_mode,
    output logic [1:0] sum_code
);
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        CARRY_ZERO = 2'b00,
        CARRY_POS  = 2'b01,
        CARRY_NEG  = 2'b11
    } carry_state_e;

    logic [CODE_W-1:0] lane_code [LANES];
    trit_e             lane_trit [LANES];
    assign lane_code[0] = a_code;
    assign lane_code[1] = b_code;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            tern_operand_in #(.CAN_NEGATE(gi == LANES - 1)) u_in (
                .code   (lane_code[gi]),
                .negate (sub_mode),
                .trit   (lane_trit[gi])
            );
        end
    endgenerate

    carry_state_e state_q, state_d;
    trit_e        stored, part_sum, c1, out_trit, c2, merged, c3;
    logic [1:0]   sum_q;

    always_comb begin
        unique case (state_q)
            CARRY_ZERO: stored = TZ;
            CARRY_POS:  stored = TP;
            CARRY_NEG:  stored = TN;
        endcase
    end

    tern_half_add u_ha_ops   (.lhs(lane_trit[0]), .rhs(lane_trit[1]), .sum(part_sum), .carry(c1));
    tern_half_add u_ha_fold  (.lhs(part_sum),     .rhs(stored),       .sum(out_trit), .carry(c2));
    tern_half_add u_ha_merge (.lhs(c1),           .rhs(c2),           .sum(merged),   .carry(c3));

    always_comb begin
        state_d = state_q;
        if (en) begin
            unique case (merged)
                TZ: state_d = CARRY_ZERO;
                TP: state_d = CARRY_POS;
                TN: state_d = CARRY_NEG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CARRY_ZERO;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)     sum_q <= 2'b00;
        else if (en) sum_q <= out_trit;
    end

    assign sum_code = sum_q;

    AST_OUT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        sum_q != 2'b10); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sum_q) && $stable(state_q))); // R8

    AST_LOSS_ONLY_TRIPLE: assert property (@(posedge clk) disable iff (rst)
        (en && c3 != TZ) |-> (lane_trit[0] == lane_trit[1] && lane_trit[1] == stored && stored != TZ)); // R5

    AST_VALUE_CONSERVED: assert property (@(posedge clk) disable iff (rst)
        (en && c3 == TZ) |=>
        (trit_value($past(lane_trit[0])) + trit_value($past(lane_trit[1])) + trit_value($past(stored))
         == trit_value(trit_decode(sum_q)) + trit_value(stored))); // R3 R4 R6

    AST_QUIET_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && lane_trit[0] == TZ && lane_trit[1] == TZ && state_q == CARRY_ZERO) |=>
        (sum_q == 2'b00 && state_q == CARRY_ZERO)); // R2
endmodule

// File: tb/tern_cf_adder_test.sv
module tern_cf_adder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] a_code = 2'b00;
    logic [1:0] b_code = 2'b00;
    logic       sub_mode = 1'b0;
    logic [1:0] sum_code;

    int checks = 0;
    int errors = 0;
    int md = 0;
    int mout = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tern_cf_adder uut (.clk(clk), .rst(rst), .en(en), .a_code(a_code),
                       .b_code(b_code), .sub_mode(sub_mode), .sum_code(sum_code));

    function automatic int clip(input int v);
        return (v > 1) ? 1 : ((v < -1) ? -1 : v);
    endfunction

    function automatic int dec(input logic [1:0] c);
        return (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
    endfunction

    function automatic logic [1:0] enc(input int v);
        return (v == 1) ? 2'b01 : ((v == -1) ? 2'b11 : 2'b00);
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [1:0] a, input logic [1:0] b,
                        input logic sb, input logic e);
        int x, y, so, c1, s, c2;
        @(negedge clk);
        a_code = a; b_code = b; sub_mode = sb; en = e;
        if (e) begin
            x  = dec(a);
            y  = sb ? -dec(b) : dec(b);
            so = clip(x + y);
            c1 = x + y - so;
            s  = clip(so + md);
            c2 = so + md - s;
            md = clip(c1 + c2);
            mout = s;
        end
        @(posedge clk);
        #1;
        check(req, sum_code, enc(mout));
        check("R10", {sum_code == 2'b10, 1'b0}, 2'b00);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        md = 0; mout = 0;
        check("R1 reset output", sum_code, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        step("R1 carry zero after reset", 2'b00, 2'b00, 1'b0, 1'b1);
    endtask

    task automatic t_plain();
        step("R2 +1+0", 2'b01, 2'b00, 1'b0, 1'b1);
        step("R2 0-1", 2'b00, 2'b11, 1'b0, 1'b1);
        step("R2 +1-1", 2'b01, 2'b11, 1'b0, 1'b1);
        step("R2 -1+1", 2'b11, 2'b01, 1'b0, 1'b1);
        step("R2 0+0", 2'b00, 2'b00, 1'b0, 1'b1);
    endtask

    task automatic t_carry();
        step("R3 +1+1 stores carry", 2'b01, 2'b01, 1'b0, 1'b1);
        step("R4 carry folded", 2'b00, 2'b00, 1'b0, 1'b1);
        step("R4 carry cleared", 2'b00, 2'b00, 1'b0, 1'b1);
        step("R3 -1-1 stores carry", 2'b11, 2'b11, 1'b0, 1'b1);
        step("R4 neg carry folded", 2'b00, 2'b00, 1'b0, 1'b1);
        check("R4 neg fold value", sum_code, 2'b11);
        step("R4 cleared", 2'b00, 2'b00, 1'b0, 1'b1);
        check("R4 zero after fold", sum_code, 2'b00);
    endtask

    task automatic t_loss_and_cancel();
        step("R5 setup", 2'b01, 2'b01, 1'b0, 1'b1);
        step("R5 triple +1 clipped", 2'b01, 2'b01, 1'b0, 1'b1);
        check("R5 output +1", sum_code, 2'b01);
        step("R5 carry kept", 2'b00, 2'b00, 1'b0, 1'b1);
        check("R5 kept carry emerges", sum_code, 2'b01);
        step("R6 setup", 2'b01, 2'b01, 1'b0, 1'b1);
        step("R6 cancel", 2'b11, 2'b11, 1'b0, 1'b1);
        check("R6 output zero", sum_code, 2'b00);
        step("R6 neg carry emerges", 2'b00, 2'b00, 1'b0, 1'b1);
        check("R6 carry became -1", sum_code, 2'b11);
    endtask

    task automatic t_subtract();
        step("R7 +1-(-1)", 2'b01, 2'b11, 1'b1, 1'b1);
        step("R7 carry from subtract", 2'b00, 2'b00, 1'b1, 1'b1);
        check("R7 subtract carry", sum_code, 2'b01);
        step("R7 +1-(+1)", 2'b01, 2'b01, 1'b1, 1'b1);
        check("R7 zero difference", sum_code, 2'b00);
        step("R7 0-(0)", 2'b00, 2'b00, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        step("R8 load", 2'b01, 2'b01, 1'b0, 1'b1);
        step("R8 idle", 2'b11, 2'b11, 1'b0, 1'b0);
        check("R8 output held", sum_code, 2'b01);
        step("R8 idle again", 2'b11, 2'b00, 1'b1, 1'b0);
        step("R8 carry held", 2'b00, 2'b00, 1'b0, 1'b1);
        check("R8 held carry emerges", sum_code, 2'b01);
    endtask

    task automatic t_spare_code();
        step("R9 spare code as zero", 2'b10, 2'b01, 1'b0, 1'b1);
        check("R9 10+1", sum_code, 2'b01);
        step("R9 spare both", 2'b10, 2'b10, 1'b1, 1'b1);
        check("R9 10+10", sum_code, 2'b00);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_carry();
        t_loss_and_cancel();
        t_subtract();
        t_hold();
        t_spare_code();
        for (int i = 0; i < 60; i++) begin
            step("R3 R4 R5 R6 mixed", 2'((i * 7) % 4), 2'((i * 5 + 1) % 4), 1'(i % 3 == 0), 1'(i % 5 != 0));
        end
        t_reset();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule